// File: doc/BRIEF.md
# Pause Frame Request Controller

This block sits between one port's flow-control request pin and the transmit scheduler. It turns changes on that pin into requests for 802.3x pause frames. When the pin rises, the block asks for a pause frame that carries the configured pause quanta. When the pin falls, it asks for a pause frame with zero quanta, but only if the release option is set. In that case the zero-time frame ends the pause at the link partner early.

A sample-enable input decides how the pin is read:

- While the enable is high, the pin is copied into an internal hold register on every clock.
- After the enable falls, the hold register captures the pin one more time, on the clock edge that ends the first cycle with the enable low.
- After that, the hold register keeps its value and further pin activity is ignored.

Edges are detected on the held value. Each edge places one request in a single-entry slot. The slot shows the pause time to the scheduler and stays there until the scheduler acknowledges it. A newer edge replaces a request that has not been acknowledged yet.

Top module: `pause_req_ctrl`

## Requirements
- R1: After reset, `req_valid` is 0 and `req_time` is 0.
- R2: With `fc_sample_en` high, a 0-to-1 change of `fc_req_pin` makes `req_valid` 1 two clock edges later, with `req_time` equal to `cfg_pause_time`.
- R3: With `cfg_zero_on_release` = 1, a 1-to-0 change of the held request raises a request with `req_time` = 0.
- R4: With `cfg_zero_on_release` = 0, a 1-to-0 change of the held request raises no request.
- R5: While `fc_sample_en` has been low for more than one cycle, changes on `fc_req_pin` raise no request.
- R6: The pin value present in the first cycle with `fc_sample_en` low is captured. Pin changes after that cycle are ignored.
- R7: A request stays valid, with a stable `req_time`, until `req_ack` is high while `req_valid` is high. It is cleared on the next edge.
- R8: A new edge that arrives while a request is unacknowledged replaces that request's `req_time` with the time of the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_req_pin | input | 1 | Flow-control request from the port |
| fc_sample_en | input | 1 | High: sample the pin live; low: hold the last captured value |
| cfg_pause_time | input | TIME_W | Pause quanta used for requests raised by a rising edge |
| cfg_zero_on_release | input | 1 | Enables a zero-time request on a falling edge |
| req_valid | output | 1 | A pause frame request is pending |
| req_time | output | TIME_W | Pause quanta for the pending request |
| req_ack | input | 1 | Scheduler accepts the pending request |

## Verification
The main sweep runs a rise, acknowledge, fall sequence for each setting of the release option and for several pause values. The values include the low bit, the top bit, all ones and mixed patterns, so a dropped or misrouted bit of `req_time` shows up. Because the fall is tried both with and without the option, a design that ignores the option is told apart from one that applies it.

Separate sequences check three more cases:

- Toggling the pin with sampling disabled separates a true hold from live sampling.
- Changing the pin in the very cycle the enable falls checks the extra capture cycle.
- Raising an edge without an acknowledge and then adding a second edge shows whether the later edge overwrites the pending request.

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_req_pin,
  input  logic              fc_sample_en,
  input  logic [TIME_W-1:0] cfg_pause_time,
  input  logic              cfg_zero_on_release,
  output logic              req_valid,
  output logic [TIME_W-1:0] req_time,
  input  logic              req_ack
);

  logic en_q, held, prev;
  logic rise, fall, capture;

  assign capture = fc_sample_en | en_q;
  assign rise    = held & ~prev;
  assign fall    = ~held & prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      held <= 1'b0;
      prev <= 1'b0;
    end else begin
      en_q <= fc_sample_en;
      if (capture) held <= fc_req_pin;
      prev <= held;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_time  <= '0;
    end else if (rise) begin
      req_valid <= 1'b1;
      req_time  <= cfg_pause_time;
    end else if (fall && cfg_zero_on_release) begin
      req_valid <= 1'b1;
      req_time  <= '0;
    end else if (req_ack) begin
      req_valid <= 1'b0;
    end
  end

  // R5
  hold_ignores_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_sample_en && !en_q) |=> $stable(held));

  // R6
  late_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !fc_sample_en) |=> held == $past(fc_req_pin));

  // R7
  pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> req_valid);

  // R7
  time_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack && held == prev) |=> $stable(req_time));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && held == prev) |=> !req_valid);

  // R4
  zero_needs_option_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_time == '0) |-> ($past(cfg_zero_on_release) || $past(cfg_pause_time) == '0));

endmodule

// File: tb/tb_pause_req_ctrl.sv
module tb_pause_req_ctrl;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, en = 1'b1, zopt = 1'b0, ack = 1'b0;
  logic [TW-1:0] ptime = '0;
  logic valid;
  logic [TW-1:0] rtime;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pause_req_ctrl #(.TIME_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .fc_req_pin(pin), .fc_sample_en(en),
    .cfg_pause_time(ptime), .cfg_zero_on_release(zopt),
    .req_valid(valid), .req_time(rtime), .req_ack(ack)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  initial begin
    logic [TW-1:0] pts [5];
    pts[0] = 16'h0001; pts[1] = 16'h8000; pts[2] = 16'hFFFF;
    pts[3] = 16'h1234; pts[4] = 16'h00FF;
    tick(2);
    chk("R1 valid", valid, 0);
    chk("R1 time", rtime, 0);
    rst_n = 1'b1;
    tick(2);

    for (int z = 0; z < 2; z++) begin
      for (int k = 0; k < 5; k++) begin
        zopt = z[0];
        ptime = pts[k];
        pin = 1'b1;
        tick(1);
        chk("R2 no early valid", valid, 0);
        tick(1);
        chk("R2 valid", valid, 1);
        chk("R2 time", rtime, pts[k]);
        tick(3);
        chk("R7 held", valid, 1);
        chk("R7 time stable", rtime, pts[k]);
        do_ack();
        chk("R7 cleared", valid, 0);
        pin = 1'b0;
        tick(2);
        if (z == 1) begin
          chk("R3 valid", valid, 1);
          chk("R3 time", rtime, 0);
          do_ack();
        end else begin
          chk("R4 no request", valid, 0);
        end
      end
    end

    zopt = 1'b1;
    ptime = 16'hA5A5;
    en = 1'b0;
    tick(2);
    pin = 1'b1;
    tick(3);
    pin = 1'b0;
    tick(1);
    pin = 1'b1;
    tick(3);
    chk("R5 ignored", valid, 0);
    pin = 1'b0;
    en = 1'b1;
    tick(3);
    chk("R5 no request on re-enable", valid, 0);

    en = 1'b0;
    pin = 1'b1;
    tick(1);
    pin = 1'b0;
    tick(1);
    chk("R6 captured valid", valid, 1);
    chk("R6 captured time", rtime, 16'hA5A5);
    do_ack();
    tick(3);
    chk("R6 later change ignored", valid, 0);
    en = 1'b1;
    tick(2);
    chk("R3 release after re-enable", valid, 1);
    chk("R3 release time", rtime, 0);
    do_ack();

    ptime = 16'h3C3C;
    pin = 1'b1;
    tick(2);
    chk("R8 first", rtime, 16'h3C3C);
    pin = 1'b0;
    tick(2);
    chk("R8 overwritten valid", valid, 1);
    chk("R8 overwritten time", rtime, 0);
    ptime = 16'h0F0F;
    pin = 1'b1;
    tick(2);
    chk("R8 overwritten again", rtime, 16'h0F0F);
    do_ack();
    chk("R7 cleared final", valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule